// File: doc/BRIEF.md
# Dual-Bank Flash Busy and Status Tracker

This block holds the control and status state of a two-bank, word-addressed flash array of 2M words of 16 bits, addressed with 21 bits. A quarter of the address space (8 Mbit) forms the small bank, bank A. It holds the fine-grained 4K-word parameter blocks next to 32K-word main blocks. The other three quarters form bank B, built from 32K-word main blocks only. A parameter selects whether the small bank sits at the top or at the bottom of the address space.

A start strobe begins a program or an erase in the bank its address decodes to. A per-bank cycle counter then stands in for the internal operation time. A read is registered with one cycle of latency, whichever bank it addresses. A read into a bank with nothing running, or into the bank that is not busy, passes the array word from the external storage. A read into a busy bank returns a status word instead. That word carries a polling bit, two toggle bits and an error flag. An erase can be suspended, so that the rest of its bank can be read or one program can run in another block of that bank. After that, the erase is resumed from where its timer stopped.

Top module: `fbs_dual_bank_status`

## Requirements
- R1: With the small bank on top (default), a word address whose two top bits are 2'b11 belongs to bank A (index 0); every other address belongs to bank B (index 1). Address 0x17FFFF is bank B and 0x180000 is bank A. Blocks are 32K words (key: address bits 20:15). The exception is the top 32K words (bits 20:15 all ones), which form eight 4K-word parameter blocks (key: bits 20:12).
- R2: After reset, rd_vld, bank_busy, bank_susp and bank_done are all zero.
- R3: An accepted program keeps bank_busy of its bank high for exactly PROG_CYC cycles, and an erase with no suspension keeps it high for exactly ERASE_CYC cycles. bank_done pulses for one cycle in the first cycle bank_busy is low again.
- R4: A read is answered one cycle after rd_en with rd_vld=1. When the addressed bank is idle, the answer is arr_q with rd_stat=0, even while the other bank is busy.
- R5: A read of a bank that is programming or erasing returns the status word with rd_stat=1. Bit 7 is the inverse of the programmed word's bit 7 during a program and 0 during an erase. Bit 6 is a toggle, bit 5 is the error flag and bit 2 is the erase toggle. All other bits are 0.
- R6: Bit 6 of a bank's status inverts after every status read of that bank, starting from 0 after reset.
- R7: Bit 2 of a bank's status inverts only after status reads whose address lies in that bank's block under erase (running or suspended). It starts from 0 after reset.
- R8: A start request to a bank that is busy is ignored: the operation's timing and polling value are unchanged. The bank's error flag (status bit 5) is set and stays set until the bank is idle.
- R9: A suspend request to a bank that is erasing sets bank_susp and freezes the erase timer. While suspended, reads outside the erase block return array data and reads inside it return status. Resume clears bank_susp, and the total busy time equals ERASE_CYC plus the cycles spent suspended.
- R10: During a suspended erase, a program start to a different block of the same bank runs for PROG_CYC cycles, with every read of that bank returning status. The bank then returns to the suspended state. A program start into the erase block is ignored and sets the error flag, and a resume while that program runs is ignored.
- R11: A suspend request to a bank that is programming, and a resume request to a bank that is not suspended, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_vld | input | 1 | Start strobe for a program or erase |
| st_erase | input | 1 | 1 = erase, 0 = program |
| st_addr | input | 21 | Word address of the operation |
| st_d7 | input | 1 | Bit 7 of the word being programmed |
| sus_vld | input | 1 | Erase suspend strobe |
| sus_bank | input | 1 | Bank to suspend (0 = A, 1 = B) |
| res_vld | input | 1 | Erase resume strobe |
| res_bank | input | 1 | Bank to resume (0 = A, 1 = B) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 21 | Read word address |
| arr_q | input | 16 | Array word at rd_addr, same cycle |
| rd_vld | output | 1 | Read answer valid |
| rd_data | output | 16 | Array word or status word |
| rd_stat | output | 1 | 1 when rd_data is a status word |
| bank_busy | output | 2 | Per-bank operation in progress |
| bank_susp | output | 2 | Per-bank erase suspended |
| bank_done | output | 2 | Per-bank one-cycle completion pulse |

## Verification
Reads are tried in four settings. The first is both banks idle, which separates plain array passing from status capture. The second is the other bank busy, which shows that bank independence holds across the 0x17FFFF/0x180000 boundary. The third is a busy bank, with repeated reads inside and outside the erase block and in a neighbouring 4K parameter block, so that the two toggles and the block granularity are told apart. The fourth is a suspended bank with a nested program, which separates the frozen erase timer, the nested busy period and the rejected requests. A seeded random phase runs many programs in bank A with random data bits and random read addresses, checking the polling bit and bank selection for every address drawn.

// File: rtl/fbs_pkg.sv
// Shared constants and types for the dual-bank status tracker.
// Assumes a word-addressed array with 32K-word main blocks and 4K-word
// parameter blocks.
package fbs_pkg;
    localparam int SECT_LSB = 15;   // 32K-word block boundary
    localparam int PBLK_LSB = 12;   // 4K-word parameter block boundary
    localparam int N_BANKS  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_ESUS,
        ST_ESPRG
    } bank_st_e;
endpackage

// File: rtl/fbs_bank_map.sv
// Address decoder: gives the bank of a word address and a block key.
// Two addresses in the same erase block produce the same key.
// Assumes the small bank is the top or bottom quarter of the space and
// that its outermost 32K words hold the 4K parameter blocks.
module fbs_bank_map #(
    parameter int ADDR_W    = 21,
    parameter bit PARAM_TOP = 1'b1,
    parameter int SECT_LSB  = 15,
    parameter int PBLK_LSB  = 12,
    localparam int KEY_W    = ADDR_W - PBLK_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank_b,
    output logic [KEY_W-1:0]  key
);
    localparam int SEC_W = ADDR_W - SECT_LSB;
    localparam int SUB_W = SECT_LSB - PBLK_LSB;

    logic [SEC_W-1:0] sector;
    logic             param_sec;
    logic             unused_lo;

    assign sector    = addr[ADDR_W-1:SECT_LSB];
    assign unused_lo = ^addr[PBLK_LSB-1:0];

    // Variant select: the small bank and its parameter sector sit at one end.
    generate
        if (PARAM_TOP) begin : g_top
            assign bank_b    = ~(&addr[ADDR_W-1 -: 2]);
            assign param_sec = &sector;
        end else begin : g_bot
            assign bank_b    = |addr[ADDR_W-1 -: 2];
            assign param_sec = ~(|sector);
        end
    endgenerate

    // Block key: fine key inside the parameter sector, coarse elsewhere.
    always_comb begin
        if (param_sec) key = addr[ADDR_W-1:PBLK_LSB];
        else           key = {sector, {SUB_W{1'b0}}};
    end
endmodule

// File: rtl/fbs_bank_ctrl.sv
// Per-bank operation tracker: busy timers, erase suspend with one nested
// program, status word and toggle bits.
// Assumes the strobes arrive already decoded to this bank, and that
// ERASE_CYC and PROG_CYC are at least 1.
module fbs_bank_ctrl
    import fbs_pkg::*;
#(
    parameter int KEY_W     = 9,
    parameter int DATA_W    = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_hit,
    input  logic              st_erase,
    input  logic [KEY_W-1:0]  st_key,
    input  logic              st_d7,
    input  logic              sus_hit,
    input  logic              res_hit,
    input  logic              rd_hit,
    input  logic [KEY_W-1:0]  rd_key,
    output logic              stat_sel,
    output logic [DATA_W-1:0] stat_word,
    output logic              busy_o,
    output logic              susp_o,
    output logic              done_o
);
    localparam int ECNT_W = $clog2(ERASE_CYC + 1);
    localparam int PCNT_W = $clog2(PROG_CYC + 1);

    bank_st_e          st_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [KEY_W-1:0]  eblk_q;
    logic              d7_q, err_q, t6_q, t2_q, done_q;
    logic              erase_open, hit_eblk, nest_ok, poll;

    // Decode of the current state for reads and nested starts.
    always_comb begin
        busy_o     = (st_q != ST_IDLE);
        susp_o     = (st_q == ST_ESUS) || (st_q == ST_ESPRG);
        erase_open = (st_q == ST_ERASE) || susp_o;
        hit_eblk   = rd_hit && erase_open && (rd_key == eblk_q);
        stat_sel   = rd_hit && (((st_q != ST_IDLE) && (st_q != ST_ESUS)) || hit_eblk);
        nest_ok    = (st_q == ST_ESUS) && !res_hit && !st_erase && (st_key != eblk_q);
        poll       = ((st_q == ST_PROG) || (st_q == ST_ESPRG)) ? ~d7_q : 1'b0;
        done_o     = done_q;
    end

    // Status word assembly.
    always_comb begin
        stat_word    = '0;
        stat_word[7] = poll;
        stat_word[6] = t6_q;
        stat_word[5] = err_q;
        stat_word[2] = t2_q;
    end

    // Operation state machine with its two countdown timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ecnt_q <= '0;
            pcnt_q <= '0;
            eblk_q <= '0;
            d7_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (st_hit) begin
                    if (st_erase) begin
                        st_q   <= ST_ERASE;
                        ecnt_q <= ECNT_W'(ERASE_CYC - 1);
                        eblk_q <= st_key;
                    end else begin
                        st_q   <= ST_PROG;
                        pcnt_q <= PCNT_W'(PROG_CYC - 1);
                        d7_q   <= st_d7;
                    end
                end
                ST_PROG: begin
                    if (pcnt_q == '0) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        pcnt_q <= pcnt_q - 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (ecnt_q == '0) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        ecnt_q <= ecnt_q - 1'b1;
                        if (sus_hit) st_q <= ST_ESUS;
                    end
                end
                ST_ESUS: begin
                    if (res_hit) begin
                        st_q <= ST_ERASE;
                    end else if (st_hit && nest_ok) begin
                        st_q   <= ST_ESPRG;
                        pcnt_q <= PCNT_W'(PROG_CYC - 1);
                        d7_q   <= st_d7;
                    end
                end
                ST_ESPRG: begin
                    if (pcnt_q == '0) st_q <= ST_ESUS;
                    else              pcnt_q <= pcnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Error flag: set by a rejected start, cleared once the bank is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err_q <= 1'b0;
        else if (st_q == ST_IDLE)                    err_q <= 1'b0;
        else if (st_hit && !nest_ok)                 err_q <= 1'b1;
    end

    // Toggle bits: bit 6 on every status read, bit 2 on erase-block reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            if (stat_sel) t6_q <= ~t6_q;
            if (hit_eblk) t2_q <= ~t2_q;
        end
    end

    // R3: completion pulse only right after a busy period.
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R3: busy can only drop together with the completion pulse.
    p_fall_gives_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R9: the erase timer holds while the erase stays suspended.
    p_timer_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_o && $past(susp_o)) |-> $stable(ecnt_q));
    // R9: suspension is only entered from a running erase.
    p_susp_from_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_o) |-> $past(st_q == ST_ERASE));
    // R8: the error flag never survives a full idle cycle.
    p_err_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> !err_q);
endmodule

// File: rtl/fbs_dual_bank_status.sv
// Top of the dual-bank status tracker: decodes the bank of starts and
// reads, runs one tracker per bank and registers the read answer, so
// that array and status reads share one cycle of latency.
// Assumes arr_q is the array word for rd_addr in the cycle of rd_en.
module fbs_dual_bank_status
    import fbs_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter bit PARAM_TOP = 1'b1,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_vld,
    input  logic              st_erase,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              st_d7,
    input  logic              sus_vld,
    input  logic              sus_bank,
    input  logic              res_vld,
    input  logic              res_bank,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_q,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_stat,
    output logic [1:0]        bank_busy,
    output logic [1:0]        bank_susp,
    output logic [1:0]        bank_done
);
    localparam int KEY_W = ADDR_W - PBLK_LSB;

    logic              st_bank, rd_bank;
    logic [KEY_W-1:0]  st_key, rd_key;
    logic [N_BANKS-1:0] stat_sel;
    logic [DATA_W-1:0] stat_word [N_BANKS];

    fbs_bank_map #(.ADDR_W(ADDR_W), .PARAM_TOP(PARAM_TOP),
                   .SECT_LSB(SECT_LSB), .PBLK_LSB(PBLK_LSB))
        u_st_map (.addr(st_addr), .bank_b(st_bank), .key(st_key));

    fbs_bank_map #(.ADDR_W(ADDR_W), .PARAM_TOP(PARAM_TOP),
                   .SECT_LSB(SECT_LSB), .PBLK_LSB(PBLK_LSB))
        u_rd_map (.addr(rd_addr), .bank_b(rd_bank), .key(rd_key));

    // One tracker per bank, each fed the strobes that decode to it.
    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            localparam logic BID = 1'(b);
            fbs_bank_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W),
                            .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
                u_bank (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .st_hit   (st_vld && (st_bank == BID)),
                    .st_erase (st_erase),
                    .st_key   (st_key),
                    .st_d7    (st_d7),
                    .sus_hit  (sus_vld && (sus_bank == BID)),
                    .res_hit  (res_vld && (res_bank == BID)),
                    .rd_hit   (rd_en && (rd_bank == BID)),
                    .rd_key   (rd_key),
                    .stat_sel (stat_sel[b]),
                    .stat_word(stat_word[b]),
                    .busy_o   (bank_busy[b]),
                    .susp_o   (bank_susp[b]),
                    .done_o   (bank_done[b])
                );
        end
    endgenerate

    // Read answer register: status of the addressed bank or array word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_stat <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) begin
                rd_stat <= stat_sel[rd_bank];
                rd_data <= stat_sel[rd_bank] ? stat_word[rd_bank] : arr_q;
            end
        end
    end

    // R4: a read of an idle bank passes the array word one cycle later.
    p_idle_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bank_busy[rd_bank]) |=> (rd_vld && !rd_stat && rd_data == $past(arr_q)));
    // R4: every read is answered in the next cycle.
    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
endmodule

// File: tb/test_fbs_dual_bank_status.sv
module test_fbs_dual_bank_status;
    localparam int P = 8;
    localparam int E = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_vld = 0, st_erase = 0, st_d7 = 0;
    logic [20:0] st_addr = '0, rd_addr = '0;
    logic        sus_vld = 0, sus_bank = 0, res_vld = 0, res_bank = 0, rd_en = 0;
    logic [15:0] arr_q, rd_data;
    logic        rd_vld, rd_stat;
    logic [1:0]  bank_busy, bank_susp, bank_done;

    int nchk = 0, nerr = 0;
    int bcnt [2];
    int scnt [2];
    bit mt6 [2];
    bit mt2 [2];
    bit merr [2];
    bit ended = 0;

    always #4 clk = ~clk;

    assign arr_q = rd_addr[15:0] ^ 16'h5A3C;

    fbs_dual_bank_status i_fbs_dual_bank_status (
        .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_erase(st_erase),
        .st_addr(st_addr), .st_d7(st_d7), .sus_vld(sus_vld), .sus_bank(sus_bank),
        .res_vld(res_vld), .res_bank(res_bank), .rd_en(rd_en), .rd_addr(rd_addr),
        .arr_q(arr_q), .rd_vld(rd_vld), .rd_data(rd_data), .rd_stat(rd_stat),
        .bank_busy(bank_busy), .bank_susp(bank_susp), .bank_done(bank_done));

    function automatic logic [15:0] pat(input logic [20:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    function automatic int bank_of(input logic [20:0] a);
        return (a[20:19] == 2'b11) ? 0 : 1;
    endfunction

    function automatic logic [15:0] sword(input bit poll, input bit t6,
                                          input bit er, input bit t2);
        logic [15:0] w = '0;
        w[7] = poll; w[6] = t6; w[5] = er; w[2] = t2;
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            bcnt[b] += int'(bank_busy[b]);
            scnt[b] += int'(bank_susp[b]);
        end
    endtask

    task automatic clr();
        for (int b = 0; b < 2; b++) begin bcnt[b] = 0; scnt[b] = 0; end
    endtask

    task automatic start(input bit er, input logic [20:0] a, input bit d7);
        st_vld = 1; st_erase = er; st_addr = a; st_d7 = d7;
        tick();
        st_vld = 0;
    endtask

    task automatic suspend(input bit b);
        sus_vld = 1; sus_bank = b; tick(); sus_vld = 0;
    endtask

    task automatic resume(input bit b);
        res_vld = 1; res_bank = b; tick(); res_vld = 0;
    endtask

    task automatic rd_arr(input logic [20:0] a, input string tag);
        rd_en = 1; rd_addr = a; tick(); rd_en = 0;
        check(rd_vld && !rd_stat && rd_data == pat(a), tag,
              {rd_vld, rd_stat, rd_data}, {2'b10, pat(a)});
    endtask

    task automatic rd_st(input int b, input logic [20:0] a, input bit poll,
                         input bit ineb, input string tag);
        logic [15:0] exp;
        exp = sword(poll, mt6[b], merr[b], mt2[b]);
        rd_en = 1; rd_addr = a; tick(); rd_en = 0;
        check(rd_vld && rd_stat && rd_data == exp, tag,
              {rd_vld, rd_stat, rd_data}, {2'b11, exp});
        mt6[b] = ~mt6[b];
        if (ineb) mt2[b] = ~mt2[b];
    endtask

    task automatic drain(input int b);
        for (int i = 0; i < 400 && bank_busy[b]; i++) tick();
        merr[b] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        // R2: reset state
        check(!rd_vld && bank_busy == 0 && bank_susp == 0 && bank_done == 0,
              "R2 reset", {rd_vld, bank_busy, bank_susp, bank_done}, 0);
        rst_n = 1;
        tick();

        // R4: idle reads in both banks
        for (int i = 0; i < 20; i++) rd_arr(21'($urandom), "R4 idle read");

        // R3/R4/R5/R6/R8: program in bank B
        clr();
        start(0, 21'h001234, 1);
        rd_arr(21'h1C0000, "R4 other bank while B busy");
        rd_st(1, 21'h0A0000, 0, 0, "R5 program status");
        rd_st(1, 21'h0A0010, 0, 0, "R6 toggle flips");
        start(0, 21'h002000, 0);
        merr[1] = 1;
        rd_st(1, 21'h001234, 0, 0, "R8 rejected start sets error");
        while (bank_busy[1]) tick();
        check(bcnt[1] == P, "R3 program busy length", bcnt[1], P);
        check(bank_done[1] == 1'b1, "R3 done pulse", bank_done, 2'b10);
        merr[1] = 0;
        tick();
        check(bank_done == 0, "R3 done one cycle", bank_done, 0);
        rd_arr(21'h001234, "R4 bank B idle again");

        // R1/R5: program in bank A, boundary addresses
        clr();
        start(0, 21'h1F8000, 0);
        rd_st(0, 21'h180000, 1, 0, "R1 0x180000 in bank A");
        rd_arr(21'h17FFFF, "R1 0x17FFFF in bank B");
        drain(0);
        check(bcnt[0] == P, "R3 bank A program length", bcnt[0], P);

        // R7/R9/R10: erase a parameter block in bank A with suspension
        clr();
        start(1, 21'h1FA000, 0);
        rd_st(0, 21'h1FA123, 0, 1, "R7 read in erase block");
        rd_st(0, 21'h1FB000, 0, 0, "R7 neighbour parameter block");
        rd_st(0, 21'h180000, 0, 0, "R5 erase status main block");
        rd_arr(21'h000040, "R4 bank B during erase");
        suspend(0);
        check(bank_susp == 2'b01, "R9 suspend flag", bank_susp, 2'b01);
        rd_arr(21'h1FB000, "R9 outside erase block while suspended");
        rd_st(0, 21'h1FA010, 0, 1, "R9 erase block while suspended");
        start(0, 21'h1FA004, 1);
        merr[0] = 1;
        rd_arr(21'h1FB004, "R10 program into erase block ignored");
        start(0, 21'h1FC000, 0);
        rd_st(0, 21'h1FC000, 1, 0, "R10 nested program status");
        rd_st(0, 21'h1FA000, 1, 1, "R10 nested program erase block");
        resume(0);
        for (int i = 0; i < 6; i++) tick();
        check(bank_susp == 2'b01, "R10 resume ignored during nested", bank_susp, 2'b01);
        rd_arr(21'h1FC000, "R10 nested program finished");
        resume(0);
        check(bank_susp == 2'b00, "R9 resume clears flag", bank_susp, 0);
        drain(0);
        check(bcnt[0] - scnt[0] == E, "R9 erase time excluding suspension",
              bcnt[0] - scnt[0], E);

        // R11: suspend during program and stray resume
        clr();
        start(0, 21'h040000, 1);
        suspend(1);
        check(bank_susp == 0, "R11 suspend during program ignored", bank_susp, 0);
        resume(0);
        check(bank_busy == 2'b10, "R11 resume of idle bank ignored", bank_busy, 2'b10);
        drain(1);
        check(bcnt[1] == P, "R11 program length unchanged", bcnt[1], P);

        // R1/R4/R5: random reads during random bank A programs
        for (int k = 0; k < 40; k++) begin
            logic [20:0] pa;
            bit d7;
            pa = {2'b11, 19'($urandom)};
            d7 = 1'($urandom);
            clr();
            start(0, pa, d7);
            for (int j = 0; j < P - 1; j++) begin
                logic [20:0] ra;
                ra = 21'($urandom);
                if (bank_of(ra) == 0) rd_st(0, ra, ~d7, 0, "R5 random status read");
                else                  rd_arr(ra, "R1 random bank B read");
            end
            drain(0);
            check(bcnt[0] == P, "R3 random program length", bcnt[0], P);
        end

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule